// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address by reading word-sized descriptors from a two-level table in memory. A requester supplies a virtual address together with the table base register. The walker reads the first-level descriptor that the top twelve address bits select. From that word's type field it either finishes at once, for a 1 MB section or a 16 MB supersection, or it makes a second, dependent read from a coarse table whose location the first descriptor names. That second read resolves a 4 KB small page.

The result carries the physical address, the control bits of the descriptor that resolved the walk, and a fault flag. Only one walk is in flight at a time. The request and response sides are valid/ready streams. The response side honours back-pressure: once `rsp_valid` rises, the response stays stable until `rsp_ready` is seen high at a clock edge. The memory read port is a valid/ready request, and the read data returns with a single valid strobe. The table base is a plain control input that is sampled only when a request is accepted.

Top module: `xlat_walker`

## Requirements
- R1: The first read of a walk goes to address {table_base[31:14], va[31:20], 2'b00}. Bits [13:0] of the base have no effect. The base and the address are sampled in the cycle the request is accepted.
- R2: A first-level word with type bits [1:0] = 2'b10 and bit 18 clear is a section. It ends the walk after one read with pa = {desc[31:20], va[19:0]}, ctrl = {12'b0, desc[19:0]} and fault = 0.
- R3: A first-level word with type 2'b10 and bit 18 set is a supersection. It ends the walk after one read with pa = {desc[31:24], va[23:0]}, ctrl = {8'b0, desc[23:0]} and fault = 0.
- R4: A first-level word with type 2'b01 makes the walker issue a second read at {desc[31:10], va[19:12], 2'b00}. The table base plays no part in this address.
- R5: A second-level word with bit 1 set is a small page: pa = {desc2[31:12], va[11:0]}, ctrl = {20'b0, desc2[11:0]}, fault = 0.
- R6: A first-level type of 2'b00 or 2'b11 ends the walk after one read with fault = 1 and pa = ctrl = 0.
- R7: A second-level type of 2'b00 or 2'b01 ends the walk after two reads with fault = 1 and pa = ctrl = 0.
- R8: `req_ready` is high only while no walk is in progress. It drops in the cycle after acceptance and returns in the cycle after the response is accepted.
- R9: While `rsp_valid` is high and `rsp_ready` is low, the response fields stay unchanged and `rsp_valid` stays high.
- R10: A memory read request keeps `mem_rd_valid` high and its address stable until `mem_rd_ready` is seen. No new read is issued while one is outstanding.
- R11: After reset, `req_ready` = 1, `rsp_valid` = 0 and `mem_rd_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_va | input | 32 | Virtual address to translate |
| table_base | input | 32 | First-level table base; bits [13:0] ignored |
| mem_rd_valid | output | 1 | Descriptor read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 32 | Byte address of the descriptor word |
| mem_rdata_valid | input | 1 | Read data strobe |
| mem_rdata | input | 32 | Descriptor word returned by memory |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_pa | output | 32 | Physical address (zero on fault) |
| rsp_ctrl | output | 32 | Non-address bits of the resolving descriptor (zero on fault) |
| rsp_fault | output | 1 | Walk ended in a translation fault |

## Verification
The assertions take for granted that memory returns exactly one data strobe per accepted read. That strobe comes at least one cycle after the acceptance and never while no read is outstanding. The check on read data arriving only in a wait state encodes this assumption. The bench memory model respects it: it raises `mem_rd_ready` only while a request is present and after a stall of zero to two cycles, then answers the captured address after a further zero to two cycles, so both handshake paths see varied timing. Descriptor contents are a pure function of the word address, and the requester holds the response for zero to two cycles before accepting it.

// File: rtl/xw_pkg.sv
package xw_pkg;
  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned SECT_SH   = 20;
  localparam int unsigned SUPER_SH  = 24;
  localparam int unsigned PAGE_SH   = 12;
  localparam int unsigned SS_BIT    = 18;
  localparam int unsigned L1_IDX_W  = ADDR_W - SECT_SH;
  localparam int unsigned L2_IDX_W  = SECT_SH - PAGE_SH;
  localparam int unsigned BASE_SH   = L1_IDX_W + 2;
  localparam int unsigned COARSE_SH = L2_IDX_W + 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1_REQ,
    ST_L1_WAIT,
    ST_L2_REQ,
    ST_L2_WAIT,
    ST_RESP
  } walk_state_e;

  typedef enum logic [1:0] {
    L1_FAULT,
    L1_BLOCK,
    L1_TABLE
  } l1_kind_e;

  typedef struct packed {
    logic [ADDR_W-1:0] pa;
    logic [ADDR_W-1:0] ctrl;
    logic              fault;
  } walk_res_t;
endpackage

// File: rtl/xw_l1_addr.sv
module xw_l1_addr
  import xw_pkg::*;
(
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] va,
  output logic [ADDR_W-1:0] addr
);
  // Base is taken as aligned to the full first-level table size.
  assign addr = {base[ADDR_W-1:BASE_SH], va[ADDR_W-1:SECT_SH], 2'b00};

  logic unused_low_bits;
  assign unused_low_bits = ^{base[BASE_SH-1:0], va[SECT_SH-1:0]};
endmodule

// File: rtl/xw_l1_decode.sv
module xw_l1_decode
  import xw_pkg::*;
(
  input  logic [ADDR_W-1:0] desc,
  input  logic [ADDR_W-1:0] va,
  output l1_kind_e          kind,
  output walk_res_t         res,
  output logic [ADDR_W-1:0] l2_addr
);
  // Coarse table pointer replaces the upper bits; base register not involved.
  assign l2_addr = {desc[ADDR_W-1:COARSE_SH], va[SECT_SH-1:PAGE_SH], 2'b00};

  always_comb begin
    kind = L1_FAULT;
    res  = '0;
    case (desc[1:0])
      2'b10: begin
        kind = L1_BLOCK;
        if (desc[SS_BIT]) begin
          res.pa   = {desc[ADDR_W-1:SUPER_SH], va[SUPER_SH-1:0]};
          res.ctrl = {{(ADDR_W-SUPER_SH){1'b0}}, desc[SUPER_SH-1:0]};
        end else begin
          res.pa   = {desc[ADDR_W-1:SECT_SH], va[SECT_SH-1:0]};
          res.ctrl = {{(ADDR_W-SECT_SH){1'b0}}, desc[SECT_SH-1:0]};
        end
      end
      2'b01: kind = L1_TABLE;
      default: begin
        kind      = L1_FAULT;
        res.fault = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/xw_l2_decode.sv
module xw_l2_decode
  import xw_pkg::*;
(
  input  logic [ADDR_W-1:0] desc,
  input  logic [ADDR_W-1:0] va,
  output walk_res_t         res
);
  always_comb begin
    res = '0;
    if (desc[1]) begin
      res.pa   = {desc[ADDR_W-1:PAGE_SH], va[PAGE_SH-1:0]};
      res.ctrl = {{(ADDR_W-PAGE_SH){1'b0}}, desc[PAGE_SH-1:0]};
    end else begin
      res.fault = 1'b1;
    end
  end

  logic unused_va_high;
  assign unused_va_high = ^va[ADDR_W-1:PAGE_SH];
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_va,
  input  logic [ADDR_W-1:0] table_base,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rdata_valid,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_pa,
  output logic [ADDR_W-1:0] rsp_ctrl,
  output logic              rsp_fault
);
  walk_state_e       state_q, state_d;
  logic [ADDR_W-1:0] va_q;
  logic [ADDR_W-1:0] addr_q;
  walk_res_t         res_q;
  logic [ADDR_W-1:0] l1_addr;
  logic [ADDR_W-1:0] l2_addr;
  l1_kind_e          l1_kind;
  walk_res_t         l1_res;
  walk_res_t         l2_res;
  logic              accept;

  xw_l1_addr u_l1_addr (
    .base (table_base),
    .va   (req_va),
    .addr (l1_addr)
  );

  xw_l1_decode u_l1_dec (
    .desc    (mem_rdata),
    .va      (va_q),
    .kind    (l1_kind),
    .res     (l1_res),
    .l2_addr (l2_addr)
  );

  xw_l2_decode u_l2_dec (
    .desc (mem_rdata),
    .va   (va_q),
    .res  (l2_res)
  );

  assign req_ready    = (state_q == ST_IDLE);
  assign mem_rd_valid = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
  assign mem_rd_addr  = addr_q;
  assign rsp_valid    = (state_q == ST_RESP);
  assign rsp_pa       = res_q.pa;
  assign rsp_ctrl     = res_q.ctrl;
  assign rsp_fault    = res_q.fault;
  assign accept       = req_valid && req_ready;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (accept) state_d = ST_L1_REQ;
      ST_L1_REQ:  if (mem_rd_ready) state_d = ST_L1_WAIT;
      ST_L1_WAIT: if (mem_rdata_valid) state_d = (l1_kind == L1_TABLE) ? ST_L2_REQ : ST_RESP;
      ST_L2_REQ:  if (mem_rd_ready) state_d = ST_L2_WAIT;
      ST_L2_WAIT: if (mem_rdata_valid) state_d = ST_RESP;
      ST_RESP:    if (rsp_ready) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      addr_q  <= '0;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        va_q   <= req_va;
        addr_q <= l1_addr;
      end
      if (state_q == ST_L1_WAIT && mem_rdata_valid) begin
        if (l1_kind == L1_TABLE) addr_q <= l2_addr;
        else                     res_q  <= l1_res;
      end
      if (state_q == ST_L2_WAIT && mem_rdata_valid) res_q <= l2_res;
    end
  end

  // R9: response is frozen under back-pressure
  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_ctrl) && $stable(rsp_fault));

  // R10: a pending read keeps its address until taken
  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  // R10: read data only ever arrives while a read is outstanding
  p_rdata_in_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rdata_valid |-> (state_q == ST_L1_WAIT || state_q == ST_L2_WAIT));

  // R8: accepted request makes the walker busy
  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R6: a faulting response carries no physical address
  p_fault_no_pa_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_pa == '0 && rsp_ctrl == '0);
endmodule

// File: tb/xlat_walker_bench.sv
`timescale 1ns/1ps
module xlat_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic [31:0] table_base = '0;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [31:0] mem_rd_addr;
  logic        mem_rdata_valid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_pa;
  logic [31:0] rsp_ctrl;
  logic        rsp_fault;

  int n_checks = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  xlat_walker u_xlat_walker (
    .clk, .rst_n, .req_valid, .req_ready, .req_va, .table_base,
    .mem_rd_valid, .mem_rd_ready, .mem_rd_addr, .mem_rdata_valid, .mem_rdata,
    .rsp_valid, .rsp_ready, .rsp_pa, .rsp_ctrl, .rsp_fault
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Descriptor contents, a pure function of the word address.
  function automatic logic [31:0] l1_word(input logic [11:0] i);
    logic [19:0] lo;
    logic [23:0] lo24;
    case (i[1:0])
      2'd0: begin
        lo = 20'(i * 13) ^ 20'h35A5C; lo[18] = 1'b0; lo[1:0] = 2'b10;
        return {i ^ 12'h5A3, lo};
      end
      2'd1: return {2'b10, 8'h00, i, i[7:0], 2'b01};
      2'd2: begin
        lo24 = 24'(i * 7) ^ 24'h09C3A5; lo24[18] = 1'b1; lo24[1:0] = 2'b10;
        return {i[7:0] ^ 8'hC3, lo24};
      end
      default: return {i ^ 12'hF0F, 18'(i * 5), (i[2] ? 2'b11 : 2'b00)};
    endcase
  endfunction

  function automatic logic [31:0] l2_word(input logic [31:0] a);
    logic [11:0] c;
    logic [7:0]  j;
    logic [11:0] lo;
    c = a[21:10];
    j = a[9:2];
    lo = {j[5:0], c[5:0]};
    lo[1:0] = j[1:0];
    return {({c, j} ^ 20'hA5F0F), lo};
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return a[31] ? l2_word(a) : l1_word(a[13:2]);
  endfunction

  // Memory model with varying stall and latency.
  int          seq = 0;
  int          gap = 0;
  int          lat = 0;
  bit          pend = 0;
  logic [31:0] cap_addr = '0;
  logic [31:0] seen_addr [2];
  int          nseen = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rd_ready = 1'b0; mem_rdata_valid = 1'b0; pend = 0; gap = 0;
    end else begin
      mem_rdata_valid = 1'b0;
      if (mem_rd_ready) begin
        mem_rd_ready = 1'b0;
        pend = 1;
        seq++;
        lat = (seq / 3) % 3;
        gap = seq % 3;
      end
      if (pend) begin
        if (lat == 0) begin
          mem_rdata_valid = 1'b1;
          mem_rdata = mem_word(cap_addr);
          pend = 0;
        end else lat--;
      end else if (mem_rd_valid) begin
        if (gap > 0) gap--;
        else begin
          mem_rd_ready = 1'b1;
          cap_addr = mem_rd_addr;
          if (nseen < 2) seen_addr[nseen] = mem_rd_addr;
          nseen++;
        end
      end
    end
  end

  task automatic do_walk(input logic [31:0] va, input logic [31:0] base, input int hold);
    logic [31:0] l1a, l2a, d, d2, epa, ectl;
    bit efault;
    int ereads, cyc;
    string tag;
    l1a = {base[31:14], va[31:20], 2'b00};
    d = mem_word(l1a);
    l2a = {d[31:10], va[19:12], 2'b00};
    d2 = mem_word(l2a);
    ereads = 1; efault = 0; epa = '0; ectl = '0;
    if (d[1:0] == 2'b10 && !d[18]) begin
      tag = "R2 section"; epa = {d[31:20], va[19:0]}; ectl = {12'b0, d[19:0]};
    end else if (d[1:0] == 2'b10) begin
      tag = "R3 supersection"; epa = {d[31:24], va[23:0]}; ectl = {8'b0, d[23:0]};
    end else if (d[1:0] == 2'b01) begin
      ereads = 2;
      if (d2[1]) begin
        tag = "R5 small page"; epa = {d2[31:12], va[11:0]}; ectl = {20'b0, d2[11:0]};
      end else begin
        tag = "R7 second-level fault"; efault = 1;
      end
    end else begin
      tag = "R6 first-level fault"; efault = 1;
    end

    @(negedge clk);
    chk(req_ready === 1'b1, "R8 ready when idle", 32'(req_ready), 32'd1);
    nseen = 0;
    req_valid = 1'b1; req_va = va; table_base = base;
    @(negedge clk);
    req_valid = 1'b0; req_va = ~va; table_base = ~base;
    chk(req_ready === 1'b0, "R8 busy after accept", 32'(req_ready), 32'd0);
    cyc = 0;
    while (rsp_valid !== 1'b1 && cyc < 100) begin
      @(negedge clk); cyc++;
    end
    chk(rsp_valid === 1'b1, "R8 response arrives", 32'(rsp_valid), 32'd1);
    chk(seen_addr[0] === l1a, "R1 first-level address", seen_addr[0], l1a);
    chk(nseen == ereads, {tag, " read count"}, 32'(nseen), 32'(ereads));
    if (ereads == 2) chk(seen_addr[1] === l2a, "R4 second-level address", seen_addr[1], l2a);
    chk(rsp_pa === epa, {tag, " pa"}, rsp_pa, epa);
    chk(rsp_ctrl === ectl, {tag, " ctrl"}, rsp_ctrl, ectl);
    chk(rsp_fault === efault, {tag, " fault"}, 32'(rsp_fault), 32'(efault));
    repeat (hold) @(negedge clk);
    if (hold > 0) begin
      chk(rsp_valid === 1'b1 && rsp_pa === epa && rsp_fault === efault,
          "R9 held under back-pressure", rsp_pa, epa);
      chk(req_ready === 1'b0, "R8 busy while response held", 32'(req_ready), 32'd0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(rsp_valid === 1'b0 && req_ready === 1'b1, "R8 idle after response taken",
        {30'b0, rsp_valid, req_ready}, 32'd1);
    chk(nseen == ereads, "R10 no extra read", 32'(nseen), 32'(ereads));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL R8 watchdog expired: actual running expected finished");
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(req_ready === 1'b1, "R11 reset req_ready", 32'(req_ready), 32'd1);
    chk(rsp_valid === 1'b0, "R11 reset rsp_valid", 32'(rsp_valid), 32'd0);
    chk(mem_rd_valid === 1'b0, "R11 reset mem_rd_valid", 32'(mem_rd_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // Full first-level sweep; base carries junk low bits (R1).
    for (int i = 0; i < 4096; i++) begin
      logic [19:0] low;
      low = 20'(i * 32'h9E37) ^ 20'h5C3A1;
      do_walk({12'(i), low}, 32'h0040_2A5C, i % 3);
    end
    // Second base, different offsets within each region.
    for (int i = 0; i < 4096; i += 7) begin
      logic [19:0] low;
      low = 20'(i * 32'h1234) ^ 20'hAB7FF;
      do_walk({12'(i), low}, 32'h1234_7FFF, (i + 1) % 3);
    end
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule